// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block is the byte store that sits behind the block-data register of an SMBus host controller. Before a block write, software writes the transfer length into the byte-count register and then writes the payload bytes, one after another, to a single block-data address. A pointer on the software side moves forward by one on every access. After a block read, software drains the received bytes through the same address. Reading the host control register moves that software pointer back to the first entry.

The protocol engine reaches the same storage through a second port with its own pointer. A transaction start returns that pointer to zero. Each transmit pop or receive push then moves it forward by one. The engine can also load the byte count that arrived on the wire. An output flags whether the current count is a legal block length.

Buffer mode is switched on and off by one bit of an auxiliary control register. A second bit of that register selects hardware packet error checking. When buffer mode is off, block-data accesses go to a single holding byte, and the buffer keeps its contents. A build parameter can leave buffer mode out altogether. In that build the enable bit always reads back as zero, so software can detect that the mode is missing.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset, the byte count and the auxiliary control register read 0, every buffer entry holds 0, both pointers are 0, and `buf_mode`, `crc_mode` and `len_ok` are low.
- R2: Register address 2 is auxiliary control. Bit 0 is the CRC enable (`crc_mode`) and bit 1 is the buffer enable (`buf_mode`). Both bits read back at those positions and every other bit reads 0. When SUPPORT_BUF is 0, bit 1 always reads back 0.
- R3: While buffer mode is on, a write to address 3 stores the byte at the software pointer, and a read of address 3 returns the byte at the software pointer. Either access then advances the pointer by one.
- R4: The software pointer stops at DEPTH-1. Further accesses keep using the last entry and do not wrap around.
- R5: A read of address 0 (host control) returns 0 and sets the software pointer to 0. A write to address 0 leaves the pointer unchanged. The protocol pointer is not affected by either.
- R6: Address 1 holds the byte count and can be written and read. `len_ok` is high exactly when the count lies in 1..DEPTH.
- R7: `xact_start` sets the protocol pointer to 0. `tx_byte` shows the entry at the protocol pointer. Each `tx_pop` advances the pointer, which stops at DEPTH-1.
- R8: `rx_push` stores `rx_byte` at the protocol pointer and advances it. `rx_cnt_load` loads `rx_cnt` into the byte count and takes priority over a software write of the count in the same cycle.
- R9: When a software write and a protocol push hit the same entry in the same cycle, the pushed byte is kept, and both pointers advance.
- R10: While buffer mode is off, block-data writes go to a holding byte and block-data reads return it. The software pointer and the buffer contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr | input | 2 | Register select: 0 host control, 1 count, 2 aux control, 3 block data |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe (side effects only) |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Read data of the selected register |
| buf_mode | output | 1 | Buffer mode active |
| crc_mode | output | 1 | Hardware CRC enable |
| len_ok | output | 1 | Byte count within 1..DEPTH |
| xact_start | input | 1 | Transaction start; rewinds protocol pointer |
| tx_pop | input | 1 | Protocol consumed `tx_byte` |
| tx_byte | output | 8 | Entry at the protocol pointer |
| rx_push | input | 1 | Store `rx_byte` at the protocol pointer |
| rx_byte | input | 8 | Received byte |
| rx_cnt_load | input | 1 | Load received count |
| rx_cnt | input | 8 | Received count value |

## Verification
A software block-data write and a protocol push can fall in the same cycle, and both can target the same entry. The bench rewinds both pointers and then drives a software write and a push together in one cycle. It then writes one more byte from software alone. Reading back through the software port shows that the pushed byte occupies entry 0 and the later write landed in entry 1, which shows that both pointers advanced exactly once. The `tx_byte` output confirms the protocol pointer's new position.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;

  typedef enum logic [1:0] {
    RS_HCTL = 2'd0,
    RS_BCNT = 2'd1,
    RS_AUX  = 2'd2,
    RS_BDAT = 2'd3
  } reg_sel_e;

  localparam int AUX_CRC_BIT = 0;
  localparam int AUX_BUF_BIT = 1;

  // Saturating increment: stays at lim once reached.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Legal block length is 1..depth.
  function automatic logic len_legal(input int unsigned n, input int unsigned depth);
    return (n >= 1) && (n <= depth);
  endfunction

endpackage

// File: rtl/smb_blkbuf_ptr.sv
module smb_blkbuf_ptr
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [IW-1:0] idx
);

  localparam logic [IW-1:0] TOP = IW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (step) idx <= IW'(sat_inc(32'(idx), DEPTH - 1));
  end

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> idx == '0);  // R5, R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && idx != TOP) |=> idx == IW'($past(idx) + 1'b1));  // R3
  AST_PTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && idx == TOP) |=> idx == TOP);  // R4

endmodule

// File: rtl/smb_blkbuf_mem.sv
module smb_blkbuf_mem #(
  parameter int DEPTH = 32,
  parameter int W = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [W-1:0]  sw_wd,
  output logic [W-1:0]  sw_q,
  input  logic          px_we,
  input  logic [IW-1:0] px_idx,
  input  logic [W-1:0]  px_wd,
  output logic [W-1:0]  px_q
);

  logic [W-1:0] ent [DEPTH];

  // Protocol push is the later assignment, so it wins on a shared entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ent[e] <= '0;
    end else begin
      if (sw_we) ent[sw_idx] <= sw_wd;
      if (px_we) ent[px_idx] <= px_wd;
    end
  end

  assign sw_q = ent[sw_idx];
  assign px_q = ent[px_idx];

  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    px_we |=> ent[$past(px_idx)] == $past(px_wd));  // R9
  AST_SW_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !(px_we && px_idx == sw_idx)) |=> ent[$past(sw_idx)] == $past(sw_wd));  // R3

endmodule

// File: rtl/smb_blkbuf_regs.sv
module smb_blkbuf_regs
  import smb_blkbuf_pkg::*;
#(
  parameter int W = 8,
  parameter bit SUPPORT_BUF = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sw_addr,
  input  logic         sw_wr,
  input  logic         sw_rd,
  input  logic [W-1:0] sw_wdata,
  input  logic [W-1:0] buf_q,
  input  logic         rx_cnt_load,
  input  logic [W-1:0] rx_cnt,
  output logic [W-1:0] sw_rdata,
  output logic         buf_en,
  output logic         crc_en,
  output logic [W-1:0] cnt,
  output logic         sw_rewind,
  output logic         sw_step,
  output logic         sw_buf_we
);

  reg_sel_e     sel;
  logic         bdat_hit;
  logic         aux_wr;
  logic         cnt_wr;
  logic         hold_wr;
  logic [W-1:0] hold;

  assign sel       = reg_sel_e'(sw_addr);
  assign bdat_hit  = (sw_wr || sw_rd) && (sel == RS_BDAT);
  assign aux_wr    = sw_wr && (sel == RS_AUX);
  assign cnt_wr    = sw_wr && (sel == RS_BCNT);
  assign hold_wr   = sw_wr && (sel == RS_BDAT) && !buf_en;
  assign sw_rewind = sw_rd && (sel == RS_HCTL);
  assign sw_step   = bdat_hit && buf_en;
  assign sw_buf_we = sw_wr && (sel == RS_BDAT) && buf_en;

  generate
    if (SUPPORT_BUF) begin : g_buf
      always_ff @(posedge clk) begin
        if (!rst_n)      buf_en <= 1'b0;
        else if (aux_wr) buf_en <= sw_wdata[AUX_BUF_BIT];
      end
    end else begin : g_nobuf
      assign buf_en = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_en <= 1'b0;
      cnt    <= '0;
      hold   <= '0;
    end else begin
      if (aux_wr)           crc_en <= sw_wdata[AUX_CRC_BIT];
      if (rx_cnt_load)      cnt    <= rx_cnt;
      else if (cnt_wr)      cnt    <= sw_wdata;
      if (hold_wr)          hold   <= sw_wdata;
    end
  end

  always_comb begin
    sw_rdata = '0;
    case (sel)
      RS_HCTL: sw_rdata = '0;
      RS_BCNT: sw_rdata = cnt;
      RS_AUX: begin
        sw_rdata[AUX_CRC_BIT] = crc_en;
        sw_rdata[AUX_BUF_BIT] = buf_en;
      end
      RS_BDAT: sw_rdata = buf_en ? buf_q : hold;
      default: sw_rdata = '0;
    endcase
  end

  AST_AUX_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr |=> crc_en == $past(sw_wdata[AUX_CRC_BIT]));  // R2
  AST_CNT_RXWIN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt_load |=> cnt == $past(rx_cnt));  // R8
  AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wr && !aux_wr) |=> (!buf_en && sel == RS_BDAT) -> (sw_rdata == $past(sw_wdata)));  // R10

endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
  import smb_blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W = 8,
  parameter bit SUPPORT_BUF = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sw_addr,
  input  logic         sw_wr,
  input  logic         sw_rd,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] sw_rdata,
  output logic         buf_mode,
  output logic         crc_mode,
  output logic         len_ok,
  input  logic         xact_start,
  input  logic         tx_pop,
  output logic [W-1:0] tx_byte,
  input  logic         rx_push,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_cnt_load,
  input  logic [W-1:0] rx_cnt
);

  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] sw_idx;
  logic [IW-1:0] px_idx;
  logic [W-1:0]  buf_q;
  logic [W-1:0]  cnt;
  logic          sw_rewind;
  logic          sw_step;
  logic          sw_buf_we;
  logic          px_step;
  logic          bdat_off_hit;

  assign px_step = tx_pop || rx_push;

  smb_blkbuf_regs #(.W(W), .SUPPORT_BUF(SUPPORT_BUF)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_wdata(sw_wdata),
    .buf_q(buf_q), .rx_cnt_load(rx_cnt_load), .rx_cnt(rx_cnt),
    .sw_rdata(sw_rdata), .buf_en(buf_mode), .crc_en(crc_mode), .cnt(cnt),
    .sw_rewind(sw_rewind), .sw_step(sw_step), .sw_buf_we(sw_buf_we)
  );

  smb_blkbuf_ptr #(.DEPTH(DEPTH)) u_sw_ptr (
    .clk(clk), .rst_n(rst_n), .clr(sw_rewind), .step(sw_step), .idx(sw_idx)
  );

  smb_blkbuf_ptr #(.DEPTH(DEPTH)) u_px_ptr (
    .clk(clk), .rst_n(rst_n), .clr(xact_start), .step(px_step), .idx(px_idx)
  );

  smb_blkbuf_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_buf_we), .sw_idx(sw_idx), .sw_wd(sw_wdata), .sw_q(buf_q),
    .px_we(rx_push), .px_idx(px_idx), .px_wd(rx_byte), .px_q(tx_byte)
  );

  assign len_ok = len_legal(32'(cnt), DEPTH);

  assign bdat_off_hit = (sw_wr || sw_rd) && (sw_addr == RS_BDAT) && !buf_mode;

  AST_OFF_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bdat_off_hit |=> $stable(sw_idx));  // R10
  AST_REWIND_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rewind && !xact_start && !px_step) |=> $stable(px_idx));  // R5

endmodule

// File: tb/sim_smb_blkbuf.sv
module sim_smb_blkbuf;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sw_addr = '0;
  logic       sw_wr = 1'b0, sw_rd = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic [7:0] sw_rdata, rdata1, tx_byte, tx1;
  logic       buf_mode, crc_mode, len_ok, bm1, cm1, lo1;
  logic       xact_start = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_cnt_load = 1'b0;
  logic [7:0] rx_byte = '0, rx_cnt = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] got;

  always #5 clk = ~clk;

  smb_blkbuf u0 (
    .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_rd(sw_rd),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .buf_mode(buf_mode), .crc_mode(crc_mode),
    .len_ok(len_ok), .xact_start(xact_start), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_cnt_load(rx_cnt_load), .rx_cnt(rx_cnt)
  );

  smb_blkbuf #(.SUPPORT_BUF(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_rd(sw_rd),
    .sw_wdata(sw_wdata), .sw_rdata(rdata1), .buf_mode(bm1), .crc_mode(cm1),
    .len_ok(lo1), .xact_start(xact_start), .tx_pop(tx_pop), .tx_byte(tx1),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_cnt_load(rx_cnt_load), .rx_cnt(rx_cnt)
  );

  typedef struct packed {
    logic       rd;
    logic [1:0] ad;
    logic [7:0] dat;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 8'h00},
    '{1'b0, 2'd1, 8'h03},
    '{1'b0, 2'd3, 8'hC1},
    '{1'b0, 2'd3, 8'hC2},
    '{1'b0, 2'd3, 8'hC3},
    '{1'b1, 2'd1, 8'h03},
    '{1'b1, 2'd0, 8'h00},
    '{1'b1, 2'd3, 8'hC1},
    '{1'b1, 2'd3, 8'hC2},
    '{1'b0, 2'd0, 8'h55},
    '{1'b1, 2'd3, 8'hC3},
    '{1'b1, 2'd0, 8'h00},
    '{1'b1, 2'd3, 8'hC1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // All tasks start just after a rising edge and end just after one.
  task automatic sw_op(input logic rd, input logic [1:0] a, input logic [7:0] d,
                       output logic [7:0] q);
    sw_addr = a; sw_wdata = d; sw_rd = rd; sw_wr = !rd;
    #2 q = sw_rdata;
    @(posedge clk); #1;
    sw_rd = 1'b0; sw_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q;
    sw_op(1'b0, a, d, q);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    sw_op(1'b1, a, 8'h00, q);
  endtask

  task automatic pulse_start();
    xact_start = 1'b1; @(posedge clk); #1; xact_start = 1'b0;
  endtask

  task automatic pop();
    tx_pop = 1'b1; @(posedge clk); #1; tx_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_byte = b; rx_push = 1'b1; @(posedge clk); #1; rx_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 buf_mode", {7'd0, buf_mode}, 8'h00);
    chk("R1 crc_mode", {7'd0, crc_mode}, 8'h00);
    chk("R1 len_ok", {7'd0, len_ok}, 8'h00);
    chk("R1 tx_byte", tx_byte, 8'h00);
    rd(2'd1, got); chk("R1 count", got, 8'h00);
    rd(2'd2, got); chk("R1 aux", got, 8'h00);

    // R2 aux control, with and without buffer support
    wr(2'd2, 8'hFF);
    #1;
    chk("R2 buf_mode", {7'd0, buf_mode}, 8'h01);
    chk("R2 crc_mode", {7'd0, crc_mode}, 8'h01);
    chk("R2 nobuf buf_mode", {7'd0, bm1}, 8'h00);
    rd(2'd2, got); chk("R2 aux readback", got, 8'h03);
    sw_addr = 2'd2; #1 chk("R2 nobuf aux readback", rdata1, 8'h01);
    wr(2'd2, 8'h02);
    rd(2'd2, got); chk("R2 crc off", got, 8'h02);

    // R3/R5 table walk
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        rd(TBL[i].ad, got);
        chk($sformatf("R3/R5 vec%0d", i), got, TBL[i].dat);
      end else begin
        wr(TBL[i].ad, TBL[i].dat);
      end
    end

    // R4 saturation at the last entry
    rd(2'd0, got);
    for (int i = 0; i < 34; i++) wr(2'd3, 8'h40 + 8'(i));
    rd(2'd0, got);
    for (int i = 0; i < 33; i++) begin
      rd(2'd3, got);
      if (i == 0)  chk("R4 entry0", got, 8'h40);
      if (i == 30) chk("R4 entry30", got, 8'h5E);
      if (i == 31) chk("R4 entry31 overwritten", got, 8'h61);
      if (i == 32) chk("R4 read stays at last", got, 8'h61);
    end

    // R7 protocol pointer
    pulse_start();
    #1 chk("R7 start shows entry0", tx_byte, 8'h40);
    pop();
    #1 chk("R7 pop advances", tx_byte, 8'h41);
    for (int i = 0; i < 40; i++) pop();
    #1 chk("R7 pop saturates", tx_byte, 8'h61);
    rd(2'd0, got);
    #1 chk("R5 rewind leaves protocol pointer", tx_byte, 8'h61);
    pulse_start();
    #1 chk("R7 restart", tx_byte, 8'h40);

    // R8 receive path
    push(8'hA0);
    push(8'hA1);
    rx_cnt = 8'd2; rx_cnt_load = 1'b1;
    sw_addr = 2'd1; sw_wdata = 8'd9; sw_wr = 1'b1;
    @(posedge clk); #1;
    rx_cnt_load = 1'b0; sw_wr = 1'b0;
    rd(2'd0, got);
    rd(2'd3, got); chk("R8 rx entry0", got, 8'hA0);
    rd(2'd3, got); chk("R8 rx entry1", got, 8'hA1);
    rd(2'd1, got); chk("R8 rx count wins", got, 8'h02);

    // R6 length legality
    wr(2'd1, 8'd0);   #1 chk("R6 len 0", {7'd0, len_ok}, 8'h00);
    wr(2'd1, 8'd1);   #1 chk("R6 len 1", {7'd0, len_ok}, 8'h01);
    wr(2'd1, 8'd32);  #1 chk("R6 len 32", {7'd0, len_ok}, 8'h01);
    wr(2'd1, 8'd33);  #1 chk("R6 len 33", {7'd0, len_ok}, 8'h00);
    wr(2'd1, 8'hFF);  #1 chk("R6 len 255", {7'd0, len_ok}, 8'h00);

    // R9 same-cycle software write and push on one entry
    rd(2'd0, got);
    pulse_start();
    sw_addr = 2'd3; sw_wdata = 8'h11; sw_wr = 1'b1;
    rx_byte = 8'h22; rx_push = 1'b1;
    @(posedge clk); #1;
    sw_wr = 1'b0; rx_push = 1'b0;
    wr(2'd3, 8'h33);
    #1 chk("R9 protocol pointer advanced", tx_byte, 8'h33);
    rd(2'd0, got);
    rd(2'd3, got); chk("R9 push wins entry0", got, 8'h22);
    rd(2'd3, got); chk("R9 sw pointer advanced", got, 8'h33);

    // R10 buffer mode off
    rd(2'd0, got);
    rd(2'd3, got);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h5A);
    rd(2'd3, got); chk("R10 holding byte", got, 8'h5A);
    wr(2'd3, 8'h5B);
    rd(2'd3, got); chk("R10 holding byte rewrite", got, 8'h5B);
    wr(2'd2, 8'h02);
    rd(2'd3, got); chk("R10 pointer held", got, 8'h33);
    rd(2'd0, got);
    rd(2'd3, got); chk("R10 contents kept", got, 8'h22);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule